// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Register Window

This block sits between a host bus and the live counters of a real-time clock. It occupies the sixteen highest word addresses of the host address space. It holds a visible copy of seven timekeeping registers, and that copy is kept apart from the counters. The host reads the clock through the visible copy. A freeze bit stops the copy from following the counters so that the host can read a coherent time, while the counters keep running. A set bit holds the counters and opens the visible copy to host writes. Clearing the set bit loads the written base time into the counters in a single load.

The host bus is synchronous. A write happens on the clock edge at which the write strobe is high. Read data is registered, so it is returned one cycle after the address is presented. The counters report each advance with a tick input and present their current time on a 56-bit bus. They receive a load strobe, the load value and a hold level from this block. A supply-good input blocks every host write while the supply is low. An oscillator-disable level is driven out from the control register.

Top module: `rtc_regwin`

## Requirements
- R1: The window is the set of word addresses whose bits above bit 3 are all one. Bits [3:0] select the offset. Offset 0 is the flag register, offset 8 is the control register, and offsets 9 to 15 are the time registers: seconds, minutes, hours, weekday, date, month and year, in that order. Offsets 1 to 7 read as 0. Reads outside the window return 0, and writes outside the window have no effect.
- R2: `bus_rdata` presents the register addressed at a clock edge during the cycle that follows that edge.
- R3: In the flag register, bit 0 is the freeze bit and bit 1 is the set bit. After reset both bits are 0, the control register is 0, all time registers are 0, and `cnt_hold` is low.
- R4: While the freeze bit and the set bit are both 0, and no commit is pending, a clock edge with `cnt_tick` high copies `cnt_time` into the visible time registers. Byte i of `cnt_time` goes to time register i.
- R5: While the freeze bit is 1 and the set bit is 0, ticks leave the visible time registers unchanged.
- R6: A write that clears a set freeze bit causes a refresh from `cnt_time` on the next clock edge, provided the set bit is 0. Every refresh, whether caused by a tick or by a freeze release, raises `snap_pulse` for exactly the one cycle that follows the refresh edge.
- R7: Writes to the time registers are ignored while the set bit is 0.
- R8: While the set bit is 1, writes to the time registers are stored, ticks do not alter the visible copy, and `cnt_hold` is high.
- R9: Suppose a write clears a set set-bit at edge E. Then `cnt_load` is high for the one cycle that follows edge E+1, and during that cycle `cnt_load_time` carries the visible time registers. `cnt_hold` stays high until that cycle ends.
- R10: Bit 7 of the control register is the oscillator-disable bit. It is writable, it reads back, and it drives `osc_off`. It is 0, meaning enabled, after reset.
- R11: While `supply_ok` is low, every host write is ignored.
- R12: Reserved bits read as 0. The writable masks are: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, date 0x3F, month 0x1F, year 0xFF, flags 0x03 and control 0x80.
- R13: `snap_pulse` and `cnt_load` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Host word address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| supply_ok | input | 1 | High when the supply is above the switch threshold |
| cnt_tick | input | 1 | One-cycle marker that the live counters advanced |
| cnt_time | input | 56 | Live counter time, seven bytes |
| cnt_load | output | 1 | One-cycle strobe that loads the base time |
| cnt_load_time | output | 56 | Base time offered to the counters |
| cnt_hold | output | 1 | Holds the counters while the time is being set |
| osc_off | output | 1 | Oscillator disable, active high |
| snap_pulse | output | 1 | One-cycle marker of a visible-copy refresh |

## Verification
A stuck freeze or set flag shows up on the next flag-register read. It also shows up through `cnt_hold` in the very next cycle. A visible copy that failed to refresh, or that refreshed when it should not have, produces a wrong time-register read one cycle after that register is addressed, and a wrong `snap_pulse` one cycle after the edge concerned. A commit that went missing or was duplicated is seen on `cnt_load` within two cycles of the write that clears the set bit, together with the value carried on `cnt_load_time`.

// File: rtl/rtc_regwin_pkg.sv
package rtc_regwin_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_TIME   = 7;
  localparam int TIME_W     = NUM_TIME * REG_W;
  localparam int OFF_FLAGS  = 0;
  localparam int OFF_CTRL   = 8;
  localparam int OFF_TIME0  = 9;
  localparam int FLG_FREEZE = 0;
  localparam int FLG_SET    = 1;
  localparam int CTRL_OSC   = 7;

  // writable bits of each time register, index 0 = seconds
  function automatic logic [REG_W-1:0] time_mask(input int idx);
    case (idx)
      0, 1:    time_mask = 8'h7F;
      2, 4:    time_mask = 8'h3F;
      3:       time_mask = 8'h07;
      5:       time_mask = 8'h1F;
      default: time_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [3:0] off_of_time(input logic [2:0] idx);
    off_of_time = 4'(OFF_TIME0) + {1'b0, idx};
  endfunction
endpackage

// File: rtl/rtc_win_decode.sv
module rtc_win_decode #(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [3:0]        off,
  output logic              time_sel,
  output logic [2:0]        time_idx
);
  import rtc_regwin_pkg::*;

  logic [3:0] idx_full;

  assign hit      = &addr[ADDR_W-1:4];
  assign off      = addr[3:0];
  assign time_sel = (off >= 4'(OFF_TIME0));
  assign idx_full = off - 4'(OFF_TIME0);
  assign time_idx = idx_full[2:0];
endmodule

// File: rtl/rtc_ctrl_flags.sv
module rtc_ctrl_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_flags,
  input  logic       we_ctrl,
  input  logic [7:0] wdata,
  output logic       freeze,
  output logic       set_q,
  output logic       r_fell,
  output logic       w_fell,
  output logic       commit_pulse,
  output logic       osc_off
);
  import rtc_regwin_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze       <= 1'b0;
      set_q        <= 1'b0;
      r_fell       <= 1'b0;
      w_fell       <= 1'b0;
      commit_pulse <= 1'b0;
      osc_off      <= 1'b0;
    end else begin
      r_fell       <= we_flags & freeze & ~wdata[FLG_FREEZE];
      w_fell       <= we_flags & set_q & ~wdata[FLG_SET];
      commit_pulse <= w_fell;
      if (we_flags) begin
        freeze <= wdata[FLG_FREEZE];
        set_q  <= wdata[FLG_SET];
      end
      if (we_ctrl) osc_off <= wdata[CTRL_OSC];
    end
  end

  AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(set_q) |=> commit_pulse); // R9
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse); // R9
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic [rtc_regwin_pkg::TIME_W-1:0]   live_time,
  input  logic                                freeze,
  input  logic                                set_q,
  input  logic                                r_fell,
  input  logic                                w_fell,
  input  logic                                commit_pulse,
  input  logic                                wr_time_req,
  input  logic [2:0]                          time_idx,
  input  logic [7:0]                          wdata,
  output logic [rtc_regwin_pkg::TIME_W-1:0]   vis_flat,
  output logic                                snap_pulse
);
  import rtc_regwin_pkg::*;

  logic refresh;
  logic wr_time_ok;

  assign refresh    = ~freeze & ~set_q & ~w_fell & ~commit_pulse & (tick | r_fell);
  assign wr_time_ok = wr_time_req & set_q;

  for (genvar gi = 0; gi < NUM_TIME; gi++) begin : g_reg
    logic [REG_W-1:0] vis_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vis_q <= '0;
      else if (refresh)
        vis_q <= live_time[gi*REG_W +: REG_W];
      else if (wr_time_ok && (time_idx == 3'(gi)))
        vis_q <= wdata & time_mask(gi);
    end
    assign vis_flat[gi*REG_W +: REG_W] = vis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_pulse <= 1'b0;
    else        snap_pulse <= refresh;
  end

  AST_TRACK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze && !set_q && !w_fell && !commit_pulse) |=> (vis_flat == $past(live_time))); // R4
  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !set_q) |=> $stable(vis_flat)); // R5
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time_req && !set_q && !tick && !r_fell) |=> $stable(vis_flat)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(snap_pulse && commit_pulse)); // R13
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              supply_ok,
  input  logic              cnt_tick,
  input  logic [55:0]       cnt_time,
  output logic              cnt_load,
  output logic [55:0]       cnt_load_time,
  output logic              cnt_hold,
  output logic              osc_off,
  output logic              snap_pulse
);
  import rtc_regwin_pkg::*;

  logic       hit, time_sel;
  logic [3:0] off;
  logic [2:0] time_idx;
  logic       host_we, we_flags, we_ctrl, wr_time_req;
  logic       freeze, set_q, r_fell, w_fell, commit_pulse;
  logic [TIME_W-1:0] vis_flat;
  logic [7:0] rd_mux;

  rtc_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .off(off), .time_sel(time_sel), .time_idx(time_idx)
  );

  assign host_we     = bus_wr & supply_ok & hit;
  assign we_flags    = host_we & (off == 4'(OFF_FLAGS));
  assign we_ctrl     = host_we & (off == 4'(OFF_CTRL));
  assign wr_time_req = host_we & time_sel;

  rtc_ctrl_flags u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_flags(we_flags), .we_ctrl(we_ctrl), .wdata(bus_wdata),
    .freeze(freeze), .set_q(set_q), .r_fell(r_fell), .w_fell(w_fell),
    .commit_pulse(commit_pulse), .osc_off(osc_off)
  );

  rtc_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .live_time(cnt_time),
    .freeze(freeze), .set_q(set_q), .r_fell(r_fell), .w_fell(w_fell),
    .commit_pulse(commit_pulse), .wr_time_req(wr_time_req), .time_idx(time_idx),
    .wdata(bus_wdata), .vis_flat(vis_flat), .snap_pulse(snap_pulse)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      if (off == 4'(OFF_FLAGS)) begin
        rd_mux[FLG_FREEZE] = freeze;
        rd_mux[FLG_SET]    = set_q;
      end else if (off == 4'(OFF_CTRL)) begin
        rd_mux[CTRL_OSC] = osc_off;
      end else if (time_sel) begin
        rd_mux = vis_flat[time_idx*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  assign cnt_load      = commit_pulse;
  assign cnt_load_time = vis_flat;
  assign cnt_hold      = set_q | w_fell | commit_pulse;

  AST_SUPPLY_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !supply_ok) |=> $stable({freeze, set_q, osc_off})); // R11
  AST_HOLD_WHILE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |-> cnt_hold); // R8
  AST_OUTSIDE_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable({freeze, set_q, osc_off})); // R1
endmodule

// File: tb/rtc_regwin_tb.sv
module rtc_regwin_tb;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          supply_ok = 1'b1;
  logic          cnt_tick = 1'b0;
  logic [55:0]   cnt_time = '0;
  logic          cnt_load;
  logic [55:0]   cnt_load_time;
  logic          cnt_hold, osc_off, snap_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit         m_r, m_w, m_osc, m_rfell, m_wfell, m_commit, m_snap;
  logic [7:0] m_vis [7];
  logic [7:0] exp_rd;

  always #4 clk = ~clk;

  rtc_regwin #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .supply_ok(supply_ok), .cnt_tick(cnt_tick), .cnt_time(cnt_time),
    .cnt_load(cnt_load), .cnt_load_time(cnt_load_time), .cnt_hold(cnt_hold),
    .osc_off(osc_off), .snap_pulse(snap_pulse)
  );

  function automatic logic [7:0] bmask(input int i);
    logic [7:0] t [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return t[i];
  endfunction

  function automatic logic [AW-1:0] win(input int o);
    return {{(AW-4){1'b1}}, 4'(o)};
  endfunction

  function automatic logic [7:0] model_read(input logic [AW-1:0] a);
    int o = int'(a[3:0]);
    if (a[AW-1:4] != {(AW-4){1'b1}}) return 8'h00;
    if (o == 0) return {6'b0, m_w, m_r};
    if (o == 8) return {m_osc, 7'b0};
    if (o >= 9) return m_vis[o-9];
    return 8'h00;
  endfunction

  function automatic logic [55:0] model_flat();
    logic [55:0] f;
    for (int i = 0; i < 7; i++) f[i*8 +: 8] = m_vis[i];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                            input bit tk, input logic [55:0] live, input bit sup);
    bit inwin = (a[AW-1:4] == {(AW-4){1'b1}});
    bit we = wr && sup && inwin;
    int o = int'(a[3:0]);
    bit refresh = !m_r && !m_w && !m_wfell && !m_commit && (tk || m_rfell);
    bit wef = we && (o == 0);
    exp_rd   = model_read(a);
    m_snap   = refresh;
    m_commit = m_wfell;
    m_wfell  = m_w && wef && !d[1];
    m_rfell  = m_r && wef && !d[0];
    if (refresh) for (int i = 0; i < 7; i++) m_vis[i] = live[i*8 +: 8];
    else if (we && m_w && o >= 9) m_vis[o-9] = d & bmask(o-9);
    if (wef) begin m_r = d[0]; m_w = d[1]; end
    if (we && o == 8) m_osc = d[7];
  endtask

  // one bus cycle: drive after a falling edge, check at the next falling edge
  task automatic step(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                      input bit tk, input logic [55:0] live, input bit sup);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_tick = tk; cnt_time = live; supply_ok = sup;
    @(posedge clk);
    model_edge(wr, a, d, tk, live, sup);
    @(negedge clk);
    chk("R2 read data", bus_rdata, exp_rd);
    chk("R6 snap_pulse", snap_pulse, m_snap);
    chk("R9 cnt_load", cnt_load, m_commit);
    if (m_commit) chk("R9 load value", cnt_load_time, model_flat());
    chk("R8 cnt_hold", cnt_hold, m_w || m_wfell || m_commit);
    chk("R10 osc_off", osc_off, m_osc);
    chk("R13 pulse overlap", snap_pulse && cnt_load, 1'b0);
  endtask

  task automatic rd(input int o, input logic [55:0] live);
    step(1'b0, win(o), 8'h00, 1'b0, live, 1'b1);
  endtask

  task automatic wrr(input int o, input logic [7:0] d, input logic [55:0] live);
    step(1'b1, win(o), d, 1'b0, live, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [55:0] l1, l2, live;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 7; i++) m_vis[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    l1 = 56'h23_08_15_04_12_34_56;
    l2 = 56'h24_11_30_06_23_59_58;

    // reset state
    rd(0, l1);
    chk("R3 flags after reset", bus_rdata, 8'h00);
    chk("R3 hold after reset", cnt_hold, 1'b0);
    rd(12, l1);
    chk("R3 time after reset", bus_rdata, 8'h00);

    // write outside the window
    step(1'b1, {4'h0, {(AW-8){1'b1}}, 4'h0}, 8'h03, 1'b0, l1, 1'b1);
    rd(0, l1);
    chk("R1 outside write", bus_rdata, 8'h00);
    step(1'b0, {(AW){1'b0}} | 19'h9, 8'h00, 1'b0, l1, 1'b1);
    chk("R1 outside read", bus_rdata, 8'h00);
    rd(3, l1);
    chk("R1 unused offset", bus_rdata, 8'h00);

    // tracking
    step(1'b0, win(9), 8'h00, 1'b1, l1, 1'b1);
    chk("R6 tick snap", snap_pulse, 1'b1);
    rd(9, l1);
    chk("R4 tracked seconds", bus_rdata, 8'h56);

    // freeze
    wrr(0, 8'h01, l1);
    step(1'b0, win(10), 8'h00, 1'b1, l2, 1'b1);
    rd(10, l2);
    chk("R5 frozen minutes", bus_rdata, 8'h34);
    wrr(0, 8'h00, l2);
    rd(10, l2);
    chk("R6 release snap", snap_pulse, 1'b1);
    rd(10, l2);
    chk("R6 refreshed minutes", bus_rdata, 8'h59);

    // writes without set bit
    wrr(9, 8'h33, l2);
    rd(9, l2);
    chk("R7 ignored write", bus_rdata, 8'h58);

    // set mode
    wrr(0, 8'h02, l2);
    wrr(9, 8'hFF, l2);
    rd(9, l2);
    chk("R12 masked seconds", bus_rdata, 8'h7F);
    chk("R8 hold high", cnt_hold, 1'b1);
    step(1'b0, win(9), 8'h00, 1'b1, l1, 1'b1);
    rd(9, l1);
    chk("R8 tick ignored", bus_rdata, 8'h7F);
    wrr(12, 8'hFF, l1);
    wrr(0, 8'h00, l1);
    chk("R9 no load yet", cnt_load, 1'b0);
    rd(12, l1);
    chk("R9 load strobe", cnt_load, 1'b1);
    chk("R9 load seconds", cnt_load_time[7:0], 8'h7F);
    chk("R12 masked weekday", cnt_load_time[31:24], 8'h07);
    rd(12, l1);
    chk("R9 load ends", cnt_load, 1'b0);
    chk("R9 hold released", cnt_hold, 1'b0);

    // supply inhibit
    step(1'b1, win(0), 8'h01, 1'b0, l1, 1'b0);
    step(1'b1, win(8), 8'h80, 1'b0, l1, 1'b0);
    rd(0, l1);
    chk("R11 flags inhibited", bus_rdata, 8'h00);
    chk("R11 osc inhibited", osc_off, 1'b0);

    // oscillator bit
    wrr(8, 8'hFF, l1);
    chk("R10 osc_off set", osc_off, 1'b1);
    rd(8, l1);
    chk("R10 control readback", bus_rdata, 8'h80);
    wrr(8, 8'h00, l1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int kind = $urandom_range(0, 9);
      logic [AW-1:0] a;
      logic [7:0] d = 8'($urandom);
      if (kind < 7) a = win($urandom_range(0, 15));
      else a = AW'($urandom);
      if (a[3:0] == 4'h0 && $urandom_range(0, 1) == 1) d = {6'($urandom), 2'($urandom)};
      live = {24'($urandom), 32'($urandom)};
      step($urandom_range(0, 2) == 0, a, d, $urandom_range(0, 3) == 0, live,
           $urandom_range(0, 7) != 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule